// File: doc/BRIEF.md
# Grouped Digital Input Debounce Filter

This block cleans up sixteen digital input lines before they reach a register file and an interrupt controller. The lines form four groups of four. Each group has its own stability-time code and its own bypass control. A filtered bit takes a new level only after the raw line has kept that level, different from the filtered one, for the programmed number of filter ticks. A group in bypass copies its raw lines straight through, one clock later.

All groups count the same filter tick. One select input picks where that tick comes from: a tick-enable pulse supplied from outside, or an internal divider on the system clock. Every accepted transition raises a one-cycle event on that channel's bit of the change vector. Downstream interrupt logic latches this vector.

Raw inputs are assumed to be synchronous to `clk` already. The tick-source select may change only while reset is asserted.

Top module: `nibble_input_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `filt_out` and `chg_evt` is 0 after that edge, whatever the raw inputs are.
- R2: Group g uses the code at `scale_code[2g+1:2g]`: 0, 1, 2 and 3 select 1, 4, 16 and 64 ticks. With ticks on every cycle and no bypass, a raw change applied before edge k shows on `filt_out` after edge k+N-1 for a stability count of N.
- R3: When a raw line returns to its filtered level before its count completes, the count starts again from zero, and no event is raised.
- R4: With `tick_sel` = 0, a count advances only on clock edges where `ext_tick` is high. Edges without a tick leave the filtered value unchanged.
- R5: When bit g of `bypass` is high, the filtered bits of group g take the raw value at the next edge. Each bit that changes raises its event.
- R6: A bit of `chg_evt` is high for exactly the one cycle in which that channel's filtered bit has just changed, and is low in every other cycle.
- R7: With `tick_sel` = 1, `ext_tick` is ignored and the tick comes from dividing the clock by DIV_RATIO (default 8). The first tick is seen at the DIV_RATIO-th edge after reset is released, and later ticks follow every DIV_RATIO edges.
- R8: Channels in the same group filter independently. A change on one line affects only that line's filtered bit and event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 16 | Raw input lines; group g is bits 4g+3..4g |
| ext_tick | input | 1 | Filter tick enable from outside, used when `tick_sel` = 0 |
| tick_sel | input | 1 | Tick source: 0 = `ext_tick`, 1 = internal clock divider |
| scale_code | input | 8 | Two-bit stability-count code per group |
| bypass | input | 4 | Per-group filter bypass |
| filt_out | output | 16 | Accepted (filtered) input state |
| chg_evt | output | 16 | One-cycle change-of-input events |

## Verification
The bench sets all four stability codes at once and changes all sixteen lines together, so that each group must accept its change in its own cycle. A wrong code decode or an off-by-one count shows up as an update one cycle early or late. A glitch shorter than the count is followed by a real change. A counter that is not cleared on the glitch accepts that later change too early. Sparse external tick pulses check that only ticking edges advance the count. The bench then resets into divider mode while holding `ext_tick` high. A design that still follows the external tick, or that starts the divider at the wrong phase, updates group 0 before the eighth edge. Bypass and single-bit changes check that events are raised per bit and not per group, and every cycle without a scheduled result must show no event and no change.

// File: rtl/nif_pkg.sv
package nif_pkg;

    localparam int NIB_COUNT = 4;
    localparam int NIB_W     = 4;
    localparam int CNT_W     = 7;   // holds counts up to 64

    typedef enum logic [1:0] {
        SCALE_1  = 2'd0,
        SCALE_4  = 2'd1,
        SCALE_16 = 2'd2,
        SCALE_64 = 2'd3
    } scale_e;

    typedef struct packed {
        scale_e scale;
        logic   bypass;
    } nib_cfg_t;

    typedef struct packed {
        logic filt;
        logic evt;
    } ch_out_t;

    // 4^code ticks of stability
    function automatic logic [CNT_W-1:0] scale_limit(scale_e s);
        return CNT_W'(1) << {s, 1'b0};
    endfunction

endpackage

// File: rtl/nif_tick_src.sv
module nif_tick_src #(
    parameter int DIV_RATIO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_tick_i,
    input  logic sel_i,
    output logic tick_o
);
    localparam int DW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + DW'(1);
    end

    assign tick_o = sel_i ? (div_q == LAST) : ext_tick_i;

    // R7: divided ticks never come on back-to-back edges
    assert_div_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_i && tick_o) |=> (!sel_i || !tick_o));

endmodule

// File: rtl/nif_channel.sv
module nif_channel
    import nif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic             tick_i,
    input  logic             bypass_i,
    input  logic [CNT_W-1:0] limit_i,
    output ch_out_t          out_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ch_out_t          st_q, st_d;

    always_comb begin
        cnt_d     = cnt_q;
        st_d.filt = st_q.filt;
        st_d.evt  = 1'b0;
        if (bypass_i) begin
            cnt_d     = '0;
            st_d.filt = raw_i;
            st_d.evt  = raw_i ^ st_q.filt;
        end else if (raw_i == st_q.filt) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q + CNT_W'(1) >= limit_i) begin
                cnt_d     = '0;
                st_d.filt = raw_i;
                st_d.evt  = 1'b1;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            st_q  <= st_d;
        end
    end

    assign out_o = st_q;

    // R6: event present exactly when the filtered bit moved
    assert_event_marks_update_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.evt == (st_q.filt != $past(st_q.filt)));

    // R4: no tick and no bypass means the filtered bit holds
    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && !tick_i) |=> $stable(st_q.filt));

    // R5: bypass copies the raw line one edge later
    assert_bypass_follows_R5: assert property (@(posedge clk) disable iff (rst)
        bypass_i |=> (st_q.filt == $past(raw_i)));

    // R3: a line back at its filtered level leaves the count at zero
    assert_restart_on_match_R3: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && raw_i == st_q.filt) |=> (cnt_q == '0));

    // R2: the count never reaches the selected limit
    assert_count_below_limit_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit_i);

endmodule

// File: rtl/nif_group.sv
module nif_group
    import nif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] raw_i,
    input  logic             tick_i,
    input  nib_cfg_t         cfg_i,
    output logic [NIB_W-1:0] filt_o,
    output logic [NIB_W-1:0] evt_o
);
    logic [CNT_W-1:0] limit;
    assign limit = scale_limit(cfg_i.scale);

    for (genvar c = 0; c < NIB_W; c++) begin : g_ch
        ch_out_t ch_out;
        nif_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .raw_i    (raw_i[c]),
            .tick_i   (tick_i),
            .bypass_i (cfg_i.bypass),
            .limit_i  (limit),
            .out_o    (ch_out)
        );
        assign filt_o[c] = ch_out.filt;
        assign evt_o[c]  = ch_out.evt;
    end

endmodule

// File: rtl/nibble_input_filter.sv
module nibble_input_filter
    import nif_pkg::*;
#(
    parameter int NIBBLES   = NIB_COUNT,
    parameter int DIV_RATIO = 8,
    localparam int CH       = NIBBLES * NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CH-1:0]      raw_in,
    input  logic               ext_tick,
    input  logic               tick_sel,
    input  logic [2*NIBBLES-1:0] scale_code,
    input  logic [NIBBLES-1:0] bypass,
    output logic [CH-1:0]      filt_out,
    output logic [CH-1:0]      chg_evt
);
    logic tick;

    nif_tick_src #(.DIV_RATIO(DIV_RATIO)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .ext_tick_i (ext_tick),
        .sel_i      (tick_sel),
        .tick_o     (tick)
    );

    for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
        nib_cfg_t cfg;
        assign cfg.scale  = scale_e'(scale_code[2*g +: 2]);
        assign cfg.bypass = bypass[g];

        nif_group u_grp (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_in[NIB_W*g +: NIB_W]),
            .tick_i (tick),
            .cfg_i  (cfg),
            .filt_o (filt_out[NIB_W*g +: NIB_W]),
            .evt_o  (chg_evt[NIB_W*g +: NIB_W])
        );
    end

    // R1: a reset edge clears both outputs
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (filt_out == '0 && chg_evt == '0));

endmodule

// File: tb/tb_nibble_input_filter.sv
module tb_nibble_input_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] raw_in;
    logic        ext_tick;
    logic        tick_sel;
    logic [7:0]  scale_code;
    logic [3:0]  bypass;
    logic [15:0] filt_out;
    logic [15:0] chg_evt;

    always #4 clk = ~clk;   // 125 MHz

    nibble_input_filter dut (
        .clk        (clk),
        .rst        (rst),
        .raw_in     (raw_in),
        .ext_tick   (ext_tick),
        .tick_sel   (tick_sel),
        .scale_code (scale_code),
        .bypass     (bypass),
        .filt_out   (filt_out),
        .chg_evt    (chg_evt)
    );

    typedef struct {
        int          cyc;
        logic [15:0] filt;
        logic [15:0] chg;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          mon_en = 0;
    logic [15:0] cur_filt = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int at, logic [15:0] f, logic [15:0] c, string r);
        exp_t it;
        int   idx;
        it.cyc = at; it.filt = f; it.chg = c; it.req = r;
        idx = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++)
            if (exp_q[i].cyc > at) begin idx = i; break; end
        exp_q.insert(idx, it);
    endtask

    task automatic check(string r, logic [15:0] act, logic [15:0] exp_v, string what);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s cyc=%0d actual=%h expected=%h", r, what, cyc, act, exp_v);
        end
    endtask

    // monitor: pops scheduled results, otherwise expects quiet outputs
    always @(negedge clk) begin
        if (mon_en) begin
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                check(it.req, filt_out, it.filt, "filt");
                check(it.req, chg_evt, it.chg, "chg");
                cur_filt = it.filt;
            end else begin
                check("R6", chg_evt, 16'h0000, "idle chg");
                check("R4", filt_out, cur_filt, "idle filt");
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int s;
        rst        = 1'b1;
        raw_in     = 16'hFFFF;
        ext_tick   = 1'b1;
        tick_sel   = 1'b0;
        scale_code = 8'b11_10_01_00;   // groups 3..0: 64,16,4,1 ticks
        bypass     = 4'b0000;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs low although raw lines are high
        check("R1", filt_out, 16'h0000, "reset filt");
        check("R1", chg_evt, 16'h0000, "reset chg");

        @(negedge clk);
        rst    = 1'b0;
        raw_in = 16'h0000;
        cur_filt = '0;
        mon_en = 1;
        repeat (3) @(negedge clk);

        // R2: every group at its own count, ticks every cycle
        s = cyc; raw_in = 16'hFFFF;
        expect_at(s + 1,  16'h000F, 16'h000F, "R2");
        expect_at(s + 4,  16'h00FF, 16'h00F0, "R2");
        expect_at(s + 16, 16'h0FFF, 16'h0F00, "R2");
        expect_at(s + 64, 16'hFFFF, 16'hF000, "R2");
        repeat (70) @(negedge clk);

        // R3: three-cycle glitch in group 1, then a real change
        s = cyc; raw_in = 16'hFF0F;
        repeat (3) @(negedge clk);
        raw_in = 16'hFFFF;
        repeat (5) @(negedge clk);
        s = cyc; raw_in = 16'hFF0F;
        expect_at(s + 4, 16'hFF0F, 16'h00F0, "R3");
        repeat (6) @(negedge clk);

        // R8: a single line inside group 0
        s = cyc; raw_in = 16'hFF0D;
        expect_at(s + 1, 16'hFF0D, 16'h0002, "R8");
        repeat (3) @(negedge clk);

        // R4: sparse external ticks, group 1 needs four of them
        s = cyc; raw_in = 16'hFFFD; ext_tick = 1'b0;
        expect_at(s + 11, 16'hFFFD, 16'h00F0, "R4");
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            ext_tick = (i == 2 || i == 5 || i == 7 || i == 10);
        end
        ext_tick = 1'b0;
        repeat (2) @(negedge clk);

        // R5: bypass on group 2, events per changed bit
        s = cyc; bypass = 4'b0100; raw_in = 16'hF0FD;
        expect_at(s + 1, 16'hF0FD, 16'h0F00, "R5");
        @(negedge clk);
        raw_in = 16'hF5FD;
        expect_at(s + 2, 16'hF5FD, 16'h0500, "R5");
        repeat (3) @(negedge clk);
        bypass = 4'b0000;
        repeat (4) @(negedge clk);

        // R7: divided tick, external tick held high and ignored
        mon_en = 0;
        rst = 1'b1; tick_sel = 1'b1; ext_tick = 1'b1; raw_in = 16'h0000;
        repeat (2) @(negedge clk);
        check("R1", filt_out, 16'h0000, "second reset filt");
        s = cyc;
        rst = 1'b0; raw_in = 16'h00FF; cur_filt = '0; mon_en = 1;
        expect_at(s + 8,  16'h000F, 16'h000F, "R7");
        expect_at(s + 32, 16'h00FF, 16'h00F0, "R7");
        repeat (40) @(negedge clk);
        mon_en = 0;

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6 unconsumed results actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule